// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether each incoming frame should be kept, based only on its 48-bit destination address. The address arrives one byte per accepted cycle, first wire byte first. While the bytes stream in, the block does two things. It folds them into an Ethernet CRC-32, and it stores them. One cycle after the sixth byte it presents an accept verdict.

Six independent filters can be enabled: any unicast, broadcast, any multicast, hashed unicast, hashed multicast and an exact station-address compare. The hashed filters use six bits of the address CRC to index a 64-entry acceptance table, which is supplied as two 32-bit words. A pass-through input overrides every filter. Each filter also owns a sticky wake flag. The flag is raised whenever that filter matches a frame, and it is cleared by pulsing a one on its bit of the clear input.

Top module: `rx_addr_filter`

## Requirements
- R1: The hash index is bits [28:23] of a CRC-32 with polynomial 0x04C11DB7 and initial value all ones, with no final inversion. The CRC covers only the six destination bytes, taken in arrival order. Each byte is fed least significant bit first, and each bit is shifted in at the CRC's most significant end.
- R2: Index values 0..31 select bit `index` of `hash_lo`. Values 32..63 select bit `index-32` of `hash_hi`. A selected bit of 1 means the hash filter matches.
- R3: The address is broadcast when all 48 bits are one. It is multicast when bit 0 of the first byte is one and it is not broadcast. Otherwise it is unicast. The hashed unicast filter applies only to unicast addresses, and the hashed multicast filter applies only to multicast addresses.
- R4: `filt_en` bit positions are: [0] any unicast, [1] broadcast, [2] any multicast, [3] hashed unicast, [4] hashed multicast, [5] station match. A filter can match only when its bit is set.
- R5: The station address is given as three 16-bit words. `sta_w2` holds byte 0 (the first on the wire) in [7:0] and byte 1 in [15:8]. `sta_w1` holds bytes 2 and 3 in the same way, and `sta_w0` holds bytes 4 and 5. The station filter matches when all six bytes are equal.
- R6: A frame is accepted when at least one enabled filter matches. Otherwise it is rejected.
- R7: When `pass_all` is high in the cycle of the sixth byte, the frame is accepted whatever the filters decide.
- R8: `dec_vld` pulses for exactly one cycle, in the cycle after the sixth byte is accepted, and `dec_accept` holds the verdict from then on. The configuration inputs are sampled in the sixth-byte cycle. A byte with `in_sof` high restarts the CRC and the byte count. Bytes after the sixth byte, and bytes after reset that come before any `in_sof`, are ignored. Idle cycles between bytes are allowed.
- R9: Each bit of `wake_flags` uses the same position as `filt_en`. A bit is set when that filter matches a frame, and it stays set until it is cleared.
- R10: A one on bit i of `wake_clr` clears flag i at the next edge. If a set and a clear reach the same bit at the same edge, the set wins.
- R11: After reset, `dec_vld`, `dec_accept` and `wake_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pass_all | input | 1 | Accept every frame regardless of filters |
| filt_en | input | 6 | Per-filter enables (positions in R4) |
| sta_w0 | input | 16 | Station bytes 5 (high) and 4 (low) |
| sta_w1 | input | 16 | Station bytes 3 (high) and 2 (low) |
| sta_w2 | input | 16 | Station bytes 1 (high) and 0 (low) |
| hash_lo | input | 32 | Acceptance table entries 0..31 |
| hash_hi | input | 32 | Acceptance table entries 32..63 |
| in_vld | input | 1 | Address byte valid |
| in_sof | input | 1 | Marks the first address byte of a frame |
| in_byte | input | 8 | Address byte |
| wake_clr | input | 6 | Write-one-to-clear pulses for the wake flags |
| dec_vld | output | 1 | One-cycle pulse when a verdict is ready |
| dec_accept | output | 1 | Verdict of the last frame |
| wake_flags | output | 6 | Sticky per-filter match flags |

## Verification
The bench goes after the class boundaries. These include an address of all ones with a single bit cleared in the last byte, and one with bit 0 of the first byte cleared. A design that tests only the group bit, or only some of the bytes, would call these broadcast or unicast wrongly. A model of the CRC that runs one bit per step picks addresses whose hash index falls in each half of the table, then sets the bit in the wrong word. This exposes a swapped table word, a reversed bit order or a wrong index slice. A station-address byte is changed at each end of the address to catch a swapped register layout. Other tests restart a frame part way through, add trailing bytes, send bytes with no start marker after reset, and clear a flag in the same cycle that it is being set. These reveal a CRC or counter that does not restart, verdicts that appear twice or at the wrong time, and a clear that wins over a set.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;

    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = ADDR_BYTES * 8;
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;
    localparam int HASH_W      = 6;
    localparam int HASH_LSB    = 23;
    localparam int TBL_ENTRIES = 1 << HASH_W;
    localparam int TBL_WORD_W  = TBL_ENTRIES / 2;
    localparam int STA_WORD_W  = 16;

    // filter slot positions (enable and wake bits share them)
    localparam int NUM_FILT      = 6;
    localparam int FI_UCAST_ALL  = 0;
    localparam int FI_BCAST      = 1;
    localparam int FI_MCAST_ALL  = 2;
    localparam int FI_UCAST_HASH = 3;
    localparam int FI_MCAST_HASH = 4;
    localparam int FI_STATION    = 5;

    typedef logic [NUM_FILT-1:0] filt_vec_t;

    typedef struct packed {
        logic bcast;
        logic mcast;
        logic ucast;
    } addr_class_t;

    // fold four data bits (d[0] first) into the CRC in one step
    function automatic logic [CRC_W-1:0] crc_fold_nibble(input logic [CRC_W-1:0] c,
                                                         input logic [3:0] d);
        logic [CRC_W-1:0] r;
        r = c << 4;
        for (int k = 0; k < 4; k++) begin
            if (c[CRC_W-1-k] ^ d[k])
                r = r ^ (CRC_POLY << (3 - k));
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c,
                                                       input logic [7:0] d);
        return crc_fold_nibble(crc_fold_nibble(c, d[3:0]), d[7:4]);
    endfunction

    // byte 0 of the address sits in a[7:0]
    function automatic addr_class_t classify(input logic [ADDR_W-1:0] a);
        addr_class_t cls;
        cls.bcast = &a;
        cls.mcast = a[0] & ~cls.bcast;
        cls.ucast = ~a[0];
        return cls;
    endfunction

endpackage

// File: rtl/rx_af_crc.sv
module rx_af_crc
    import rx_af_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              restart,
    input  logic [7:0]        din,
    output logic [HASH_W-1:0] hash_next
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    assign crc_next  = crc_fold_byte(restart ? CRC_SEED : crc_q, din);
    assign hash_next = crc_next[HASH_LSB +: HASH_W];

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= CRC_SEED;
        else if (step)
            crc_q <= crc_next;
    end
endmodule

// File: rtl/rx_af_match.sv
module rx_af_match
    import rx_af_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [HASH_W-1:0]     hash_idx,
    input  filt_vec_t             en,
    input  logic [STA_WORD_W-1:0] sta_w0,
    input  logic [STA_WORD_W-1:0] sta_w1,
    input  logic [STA_WORD_W-1:0] sta_w2,
    input  logic [TBL_WORD_W-1:0] hash_lo,
    input  logic [TBL_WORD_W-1:0] hash_hi,
    output filt_vec_t             hits
);
    addr_class_t              cls;
    logic [TBL_ENTRIES-1:0]   table_bits;
    logic [ADDR_W-1:0]        station;
    logic                     tbl_hit;
    filt_vec_t                raw;

    assign cls        = classify(addr);
    assign table_bits = {hash_hi, hash_lo};
    assign tbl_hit    = table_bits[hash_idx];
    assign station    = {sta_w0, sta_w1, sta_w2};

    always_comb begin
        raw                = '0;
        raw[FI_UCAST_ALL]  = cls.ucast;
        raw[FI_BCAST]      = cls.bcast;
        raw[FI_MCAST_ALL]  = cls.mcast;
        raw[FI_UCAST_HASH] = cls.ucast & tbl_hit;
        raw[FI_MCAST_HASH] = cls.mcast & tbl_hit;
        raw[FI_STATION]    = (addr == station);
    end

    assign hits = raw & en;
endmodule

// File: rtl/rx_af_wake.sv
module rx_af_wake
    import rx_af_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  filt_vec_t set_vec,
    input  filt_vec_t clr_vec,
    output filt_vec_t flags
);
    for (genvar g = 0; g < NUM_FILT; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[g] <= 1'b0;
            else if (set_vec[g])
                flags[g] <= 1'b1;
            else if (clr_vec[g])
                flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_af_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pass_all,
    input  logic [NUM_FILT-1:0]   filt_en,
    input  logic [STA_WORD_W-1:0] sta_w0,
    input  logic [STA_WORD_W-1:0] sta_w1,
    input  logic [STA_WORD_W-1:0] sta_w2,
    input  logic [TBL_WORD_W-1:0] hash_lo,
    input  logic [TBL_WORD_W-1:0] hash_hi,
    input  logic                  in_vld,
    input  logic                  in_sof,
    input  logic [7:0]            in_byte,
    input  logic [NUM_FILT-1:0]   wake_clr,
    output logic                  dec_vld,
    output logic                  dec_accept,
    output logic [NUM_FILT-1:0]   wake_flags
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    idx;
    logic                take;
    logic                last;
    logic [ADDR_W-9:0]   addr_q;
    logic [ADDR_W-1:0]   full_addr;
    logic [HASH_W-1:0]   hash_idx;
    filt_vec_t           hits;
    filt_vec_t           wake_set;

    // byte position tracking: CNT_IDLE means no frame in progress
    assign idx  = in_sof ? '0 : cnt_q;
    assign take = in_vld && (in_sof || (cnt_q < CNT_IDLE));
    assign last = take && (idx == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_IDLE;
        else if (take)
            cnt_q <= idx + 1'b1;
    end

    for (genvar b = 0; b < ADDR_BYTES - 1; b++) begin : g_cap
        always_ff @(posedge clk) begin
            if (take && idx == CNT_W'(b))
                addr_q[b*8 +: 8] <= in_byte;
        end
    end

    assign full_addr = {in_byte, addr_q};

    rx_af_crc u_crc (
        .clk       (clk),
        .rst       (rst),
        .step      (take),
        .restart   (in_sof),
        .din       (in_byte),
        .hash_next (hash_idx)
    );

    rx_af_match u_match (
        .addr     (full_addr),
        .hash_idx (hash_idx),
        .en       (filt_en),
        .sta_w0   (sta_w0),
        .sta_w1   (sta_w1),
        .sta_w2   (sta_w2),
        .hash_lo  (hash_lo),
        .hash_hi  (hash_hi),
        .hits     (hits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_vld <= last;
            if (last)
                dec_accept <= pass_all | (|hits);
        end
    end

    assign wake_set = last ? hits : '0;

    rx_af_wake u_wake (
        .clk     (clk),
        .rst     (rst),
        .set_vec (wake_set),
        .clr_vec (wake_clr),
        .flags   (wake_flags)
    );
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
    import rx_af_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                pass_all,
    input logic [NUM_FILT-1:0] filt_en,
    input logic                in_vld,
    input logic [NUM_FILT-1:0] wake_clr,
    input logic                dec_vld,
    input logic                dec_accept,
    input logic [NUM_FILT-1:0] wake_flags
);
    AST_PASS_ALL_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && $past(pass_all)) |-> dec_accept); // R7

    AST_NO_FILTER_REJECTS: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && !$past(pass_all) && ($past(filt_en) == '0)) |-> !dec_accept); // R6

    AST_DEC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        dec_vld |=> !dec_vld); // R8

    AST_DEC_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> $past(in_vld)); // R8

    AST_FLAG_RISE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        ((wake_flags & ~$past(wake_flags)) != '0) |-> (dec_vld && dec_accept)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((wake_flags & $past(wake_flags & ~wake_clr)) == $past(wake_flags & ~wake_clr))); // R9

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !dec_vld |-> ((wake_flags & $past(wake_clr)) == '0)); // R10
endmodule

bind rx_addr_filter rx_addr_filter_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .pass_all   (pass_all),
    .filt_en    (filt_en),
    .in_vld     (in_vld),
    .wake_clr   (wake_clr),
    .dec_vld    (dec_vld),
    .dec_accept (dec_accept),
    .wake_flags (wake_flags)
);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pass_all = 1'b0;
    logic [5:0]  filt_en = '0;
    logic [15:0] sta_w0 = 16'h5544;
    logic [15:0] sta_w1 = 16'h3322;
    logic [15:0] sta_w2 = 16'h1102;
    logic [31:0] hash_lo = '0;
    logic [31:0] hash_hi = '0;
    logic        in_vld = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [5:0]  wake_clr = '0;
    logic        dec_vld;
    logic        dec_accept;
    logic [5:0]  wake_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst(rst), .pass_all(pass_all), .filt_en(filt_en),
        .sta_w0(sta_w0), .sta_w1(sta_w1), .sta_w2(sta_w2),
        .hash_lo(hash_lo), .hash_hi(hash_hi),
        .in_vld(in_vld), .in_sof(in_sof), .in_byte(in_byte), .wake_clr(wake_clr),
        .dec_vld(dec_vld), .dec_accept(dec_accept), .wake_flags(wake_flags)
    );

    localparam logic [47:0] STA = 48'h5544_3322_1102;
    localparam logic [47:0] UNI = 48'h1234_5678_9A00;
    localparam logic [47:0] MC  = 48'h0000_005E_0001;
    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] NBC = 48'h7FFF_FFFF_FFFF;
    localparam logic [47:0] NUC = 48'hFFFF_FFFF_FFFE;

    // {addr, enables, pass_all, hash mode, expected accept, expected flags}
    // hash mode: 0 empty table, 1 only model bit, 2 all but model bit, 3 full
    localparam int NV = 22;
    localparam logic [63:0] VECS [NV] = '{
        {STA, 6'b100000, 1'b0, 2'd0, 1'b1, 6'b100000},             // R5
        {48'h5644_3322_1102, 6'b100000, 1'b0, 2'd0, 1'b0, 6'b0},   // R5 byte 5
        {48'h5544_3322_1103, 6'b100000, 1'b0, 2'd0, 1'b0, 6'b0},   // R5 byte 0
        {UNI, 6'b000001, 1'b0, 2'd0, 1'b1, 6'b000001},             // R4
        {UNI, 6'b000110, 1'b0, 2'd0, 1'b0, 6'b0},                  // R3
        {BC,  6'b000010, 1'b0, 2'd0, 1'b1, 6'b000010},             // R4
        {BC,  6'b000101, 1'b0, 2'd0, 1'b0, 6'b0},                  // R3
        {MC,  6'b000100, 1'b0, 2'd0, 1'b1, 6'b000100},             // R4
        {MC,  6'b000001, 1'b0, 2'd0, 1'b0, 6'b0},                  // R3
        {NBC, 6'b000100, 1'b0, 2'd0, 1'b1, 6'b000100},             // R3
        {NBC, 6'b000010, 1'b0, 2'd0, 1'b0, 6'b0},                  // R3
        {NUC, 6'b000001, 1'b0, 2'd0, 1'b1, 6'b000001},             // R3
        {UNI, 6'b001000, 1'b0, 2'd1, 1'b1, 6'b001000},             // R1
        {UNI, 6'b001000, 1'b0, 2'd2, 1'b0, 6'b0},                  // R1
        {MC,  6'b010000, 1'b0, 2'd1, 1'b1, 6'b010000},             // R1
        {MC,  6'b010000, 1'b0, 2'd2, 1'b0, 6'b0},                  // R1
        {MC,  6'b001000, 1'b0, 2'd1, 1'b0, 6'b0},                  // R3
        {BC,  6'b010000, 1'b0, 2'd3, 1'b0, 6'b0},                  // R3
        {STA, 6'b111111, 1'b0, 2'd3, 1'b1, 6'b101001},             // R6
        {UNI, 6'b000000, 1'b1, 2'd0, 1'b1, 6'b0},                  // R7
        {BC,  6'b100000, 1'b1, 2'd0, 1'b1, 6'b0},                  // R7
        {UNI, 6'b000000, 1'b0, 2'd3, 1'b0, 6'b0}                   // R6
    };

    function automatic logic [5:0] model_idx(input logic [47:0] a);
        logic [31:0] c;
        logic fb;
        c = '1;
        for (int i = 0; i < 48; i++) begin
            fb = c[31] ^ a[i];
            c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
        end
        return c[28:23];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_table(input logic [1:0] mode, input logic [47:0] a);
        logic [63:0] t;
        case (mode)
            2'd0: t = '0;
            2'd1: t = 64'd1 << model_idx(a);
            2'd2: t = ~(64'd1 << model_idx(a));
            default: t = '1;
        endcase
        hash_lo = t[31:0];
        hash_hi = t[63:32];
    endtask

    task automatic clear_all();
        @(negedge clk); wake_clr = '1;
        @(negedge clk); wake_clr = '0;
    endtask

    // leaves the bench at the negedge where the verdict is visible
    task automatic send_frame(input logic [47:0] a, input logic [5:0] clr_last, input bit gaps);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_vld   = 1'b1;
            in_sof   = (i == 0);
            in_byte  = a[8*i +: 8];
            wake_clr = (i == 5) ? clr_last : 6'b0;
            if (gaps && i < 5) begin
                @(negedge clk);
                in_vld = 1'b0; in_sof = 1'b0; wake_clr = '0;
            end
        end
        @(negedge clk);
        in_vld = 1'b0; in_sof = 1'b0; wake_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [47:0] lo_a, hi_a;
        logic [5:0]  ix;
        bit seen, got_lo, got_hi;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 dec_vld", dec_vld, 0);
        chk("R11 dec_accept", dec_accept, 0);
        chk("R11 wake_flags", wake_flags, 0);

        // R8: bytes with no start marker after reset are ignored
        filt_en = 6'b000001;
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            seen |= dec_vld;
            in_vld = (i < 6); in_sof = 1'b0; in_byte = UNI[8*(i%6) +: 8];
        end
        in_vld = 1'b0;
        chk("R8 no sof ignored", seen, 0);
        chk("R8 no sof flags", wake_flags, 0);

        // table-driven cases
        for (int v = 0; v < NV; v++) begin
            logic [47:0] a;
            a = VECS[v][63:16];
            clear_all();
            filt_en  = VECS[v][15:10];
            pass_all = VECS[v][9];
            set_table(VECS[v][8:7], a);
            send_frame(a, 6'b0, 1'b0);
            chk($sformatf("R8 vec%0d vld", v), dec_vld, 1);
            chk($sformatf("R6 vec%0d accept", v), dec_accept, VECS[v][6]);
            chk($sformatf("R9 vec%0d flags", v), wake_flags, VECS[v][5:0]);
        end
        pass_all = 1'b0;

        // R8: single pulse, trailing bytes ignored
        filt_en = 6'b100000; set_table(2'd0, STA);
        send_frame(STA, 6'b0, 1'b0);
        chk("R8 pulse high", dec_vld, 1);
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            seen |= dec_vld;
            in_vld = (i < 4); in_byte = 8'hA5;
        end
        in_vld = 1'b0;
        chk("R8 one pulse and trailing bytes ignored", seen, 0);
        chk("R8 verdict held", dec_accept, 1);

        // R8: restart mid-frame resets the CRC
        filt_en = 6'b001000; set_table(2'd1, UNI);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_vld = 1'b1; in_sof = (i == 0); in_byte = 8'h5A + 8'(i);
        end
        send_frame(UNI, 6'b0, 1'b0);
        chk("R8 restart vld", dec_vld, 1);
        chk("R8 restart accept", dec_accept, 1);

        // R8: idle gaps between bytes
        filt_en = 6'b100000; set_table(2'd0, STA);
        send_frame(STA, 6'b0, 1'b1);
        chk("R8 gaps vld", dec_vld, 1);
        chk("R8 gaps accept", dec_accept, 1);

        // R2: table halves, found with the bit-serial model
        got_lo = 0; got_hi = 0; lo_a = '0; hi_a = '0;
        for (int k = 1; k < 400 && !(got_lo && got_hi); k++) begin
            logic [47:0] a;
            a = 48'(k) << 8;
            if (model_idx(a) < 32 && !got_lo) begin lo_a = a; got_lo = 1; end
            if (model_idx(a) >= 32 && !got_hi) begin hi_a = a; got_hi = 1; end
        end
        filt_en = 6'b001000;
        ix = model_idx(lo_a);
        hash_lo = 32'd1 << ix[4:0]; hash_hi = '0;
        send_frame(lo_a, 6'b0, 1'b0);
        chk("R2 low word accept", dec_accept, 1);
        hash_hi = 32'd1 << ix[4:0]; hash_lo = '0;
        send_frame(lo_a, 6'b0, 1'b0);
        chk("R2 low index in high word rejects", dec_accept, 0);
        ix = model_idx(hi_a);
        hash_hi = 32'd1 << ix[4:0]; hash_lo = '0;
        send_frame(hi_a, 6'b0, 1'b0);
        chk("R2 high word accept", dec_accept, 1);
        hash_lo = 32'd1 << ix[4:0]; hash_hi = '0;
        send_frame(hi_a, 6'b0, 1'b0);
        chk("R2 high index in low word rejects", dec_accept, 0);

        // R9 / R10: sticky flags and clearing
        clear_all();
        hash_lo = '0; hash_hi = '0;
        filt_en = 6'b000011;
        send_frame(UNI, 6'b0, 1'b0);
        chk("R9 first flag", wake_flags, 6'b000001);
        send_frame(BC, 6'b0, 1'b0);
        chk("R9 flags accumulate", wake_flags, 6'b000011);
        filt_en = 6'b000000;
        send_frame(UNI, 6'b0, 1'b0);
        chk("R9 flags kept on reject", wake_flags, 6'b000011);
        @(negedge clk); wake_clr = 6'b000001;
        @(negedge clk); wake_clr = 6'b0;
        chk("R10 clear one bit", wake_flags, 6'b000010);
        @(negedge clk); wake_clr = 6'b100100;
        @(negedge clk); wake_clr = 6'b0;
        chk("R10 clear of zero bits no effect", wake_flags, 6'b000010);
        filt_en = 6'b000010;
        send_frame(BC, 6'b000010, 1'b0);
        chk("R10 set wins over clear", wake_flags, 6'b000010);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule